// File: doc/BRIEF.md
# Banked GPIO Register File

This block is a general-purpose I/O controller organised as up to eight banks of up to eight pins each. A byte-wide register port reaches it. The port has an 8-bit register index, a write strobe and write data, and it returns read data. Each bank owns a window of four registers that starts at its own base index. Through that window software sets which pins drive, the level they drive and the driver style, and it reads back the pad levels.

Each pin drives its pad through an output-enable and an output-value signal. A pin set to push-pull drives both levels. A pin set to open-drain pulls low only when its data bit is 0 and otherwise releases the pad. Pad inputs pass through a two-flop synchronizer before they reach the input status register. A bank may have fewer than eight pins. Missing pins read as zero, ignore writes and never drive.

The bank bases and pin counts are parameters. The default layout has eight banks with bases 0xF0, 0xE0, 0xD0, 0xC0, 0xB0, 0xA0, 0x90 and 0x88, and with 6, 8, 8, 4, 5, 7, 8 and 8 pins respectively (bank 0 first).

Top module: `gpio_bank_regfile`

## Requirements
- R1: After a synchronous active-low reset every register is 0: all pins are inputs in open-drain mode, and every pad_oe and pad_out bit is 0.
- R2: Within a bank the offset from its base selects the register: +0 direction, +1 output data, +2 input status, +3 output mode. A write takes effect at the clock edge on which reg_wr is high.
- R3: A direction bit of 1 makes its pin an output. A direction bit of 0 makes it an input, and the pin's pad_oe is then 0.
- R4: An output pin whose mode bit is 1 (push-pull) has pad_oe 1 and pad_out equal to its output data bit.
- R5: An output pin whose mode bit is 0 (open-drain) has pad_oe 1 and pad_out 0 when its data bit is 0. When its data bit is 1 it has pad_oe 0 and pad_out 0.
- R6: Output data written while a pin is an input is kept. The pin drives that level as soon as its direction bit is set.
- R7: The input status register is read-only; a write to it changes nothing. It returns the pad_in level two clock edges after the change, whatever the direction setting.
- R8: Bits for pins that a bank does not implement read as 0, ignore writes and never assert pad_oe or pad_out.
- R9: An index that falls in no bank's window reads as 0x00, and a write to it has no effect.
- R10: reg_rdata follows reg_idx combinationally in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_idx |
| pad_in | input | NUM_BANKS*8 | Raw pad levels, bank b pin p at bit b*8+p |
| pad_oe | output | NUM_BANKS*8 | Pad output enable, same bit layout |
| pad_out | output | NUM_BANKS*8 | Pad output value, same bit layout |

## Verification
On every cycle the assertions check four things: that no open-drain pin drives a high level, that missing pins stay silent, that a direction write lands masked by the implemented pins, and that a status write leaves a bank's registers stable. They also check that the synchronized levels lag pad_in by exactly two edges and that at most one bank claims an index. Only the bench's scenarios can show the whole address map, which needs sweeps of all 256 indices for writes and reads. The same holds for the read value of unmapped holes, for driving a preloaded level when a pin turns into an output, and for status reads that ignore the direction setting.

// File: rtl/gpio_regfile_pkg.sv
// Shared definitions for the banked GPIO register file.
// Assumes bank windows are four registers long and aligned to four.
package gpio_regfile_pkg;

    // Register selected by the two low index bits within a bank window.
    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_DOUT = 2'd1,
        REG_STAT = 2'd2,
        REG_MODE = 2'd3
    } reg_sel_e;

    // Mask of implemented pins for a bank of the given width.
    function automatic logic [7:0] pin_mask(input int pins);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < pins) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the raw pad inputs.
// Assumes pad_in is asynchronous to clk; all flops clear on reset.
module gpio_in_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [1:0]       age_q;

    // Shift the pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    // Count edges since reset (saturating) so the latency check starts only after the pipe fills.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assign pad_sync = sync_q;

    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_q == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_bank.sv
// One GPIO bank: direction, output data and output mode registers,
// read port for its four-register window, and the pad driver logic.
// Assumes BASE is aligned to four and PINS is between 1 and W.
module gpio_bank
    import gpio_regfile_pkg::*;
#(
    parameter int         W    = 8,
    parameter int         PINS = 8,
    parameter logic [7:0] BASE = 8'hF0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   idx,
    input  logic         wr_en,
    input  logic [7:0]   wdata,
    input  logic [W-1:0] pin_sync,
    output logic         hit,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] oe,
    output logic [W-1:0] drv
);
    localparam logic [W-1:0] MASK = W'(pin_mask(PINS));

    logic [W-1:0] dir_q;
    logic [W-1:0] dout_q;
    logic [W-1:0] mode_q;
    reg_sel_e     sel;

    // Decode whether the index falls in this bank's window.
    always_comb begin
        hit = (idx[7:2] == BASE[7:2]);
        sel = reg_sel_e'(idx[1:0]);
    end

    // Update the writable registers; the status register takes no write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            mode_q <= '0;
        end else if (wr_en && hit) begin
            case (sel)
                REG_DIR:  dir_q  <= wdata[W-1:0] & MASK;
                REG_DOUT: dout_q <= wdata[W-1:0] & MASK;
                REG_MODE: mode_q <= wdata[W-1:0] & MASK;
                default:  ;
            endcase
        end
    end

    // Return the register chosen by the low index bits.
    always_comb begin
        case (sel)
            REG_DIR:  rd_data = dir_q;
            REG_DOUT: rd_data = dout_q;
            REG_STAT: rd_data = pin_sync & MASK;
            default:  rd_data = mode_q;
        endcase
    end

    // Drive pads: push-pull drives both levels, open-drain only pulls low.
    always_comb begin
        oe  = dir_q & (mode_q | ~dout_q) & MASK;
        drv = oe & dout_q;
    end

    // R5
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv & ~mode_q) == '0));

    // R8
    unimpl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((oe | drv | dir_q | dout_q | mode_q) & ~MASK) == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && idx[1:0] == 2'd0) |=> (dir_q == ($past(wdata[W-1:0]) & MASK)));

    // R7
    stat_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && idx[1:0] == 2'd2) |=>
            ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

endmodule

// File: rtl/gpio_rd_mux.sv
// Combines per-bank read data into the port read value.
// Assumes bank windows do not overlap; an index no bank claims reads zero.
module gpio_rd_mux #(
    parameter int NB = 8,
    parameter int W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB-1:0]   hits,
    input  logic [NB*W-1:0] bank_data,
    output logic [W-1:0]    rdata
);
    // OR together the data of the bank (if any) that claims the index.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (hits[b]) rdata = rdata | bank_data[b*W +: W];
        end
    end

    // R2
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));

endmodule

// File: rtl/gpio_bank_regfile.sv
// Top of the banked GPIO register file: pad input synchronizer, one
// gpio_bank per configured bank, and the read-data combiner.
// Assumes BANK_BASE entries are distinct, aligned to four, and that
// BANK_PINS entries lie between 1 and 8.
module gpio_bank_regfile #(
    parameter int                       NUM_BANKS = 8,
    parameter logic [NUM_BANKS*8-1:0]   BANK_BASE = {8'h88, 8'h90, 8'hA0, 8'hB0,
                                                     8'hC0, 8'hD0, 8'hE0, 8'hF0},
    parameter logic [NUM_BANKS*4-1:0]   BANK_PINS = {4'd8, 4'd8, 4'd7, 4'd5,
                                                     4'd4, 4'd8, 4'd8, 4'd6}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             reg_idx,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [NUM_BANKS*8-1:0] pad_in,
    output logic [NUM_BANKS*8-1:0] pad_oe,
    output logic [NUM_BANKS*8-1:0] pad_out
);
    localparam int W     = 8;
    localparam int NPADS = NUM_BANKS * W;

    logic [NPADS-1:0]     pad_sync;
    logic [NUM_BANKS-1:0] hits;
    logic [NPADS-1:0]     bank_rd;

    gpio_in_sync #(.WIDTH(NPADS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(
            .W    (W),
            .PINS (int'(BANK_PINS[b*4 +: 4])),
            .BASE (BANK_BASE[b*8 +: 8])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (reg_idx),
            .wr_en    (reg_wr),
            .wdata    (reg_wdata),
            .pin_sync (pad_sync[b*W +: W]),
            .hit      (hits[b]),
            .rd_data  (bank_rd[b*W +: W]),
            .oe       (pad_oe[b*W +: W]),
            .drv      (pad_out[b*W +: W])
        );
    end

    gpio_rd_mux #(.NB(NUM_BANKS), .W(W)) u_rd_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hits),
        .bank_data (bank_rd),
        .rdata     (reg_rdata)
    );

endmodule

// File: tb/tb_gpio_bank_regfile.sv
module tb_gpio_bank_regfile;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_idx = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NB*8-1:0] pad_in = '0;
    logic [NB*8-1:0] pad_oe;
    logic [NB*8-1:0] pad_out;

    int vectors = 0;
    int miscompares = 0;

    // Bench copy of the default layout.
    logic [7:0] base_t [NB] = '{8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0, 8'h90, 8'h88};
    int         pins_t [NB] = '{6, 8, 8, 4, 5, 7, 8, 8};

    logic [7:0] m_dir [NB];
    logic [7:0] m_dat [NB];
    logic [7:0] m_mode [NB];

    always #10 clk = ~clk;

    gpio_bank_regfile dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [7:0] msk(input int b);
        return 8'((16'd1 << pins_t[b]) - 16'd1);
    endfunction

    function automatic int bank_of(input logic [7:0] i);
        for (int b = 0; b < NB; b++) if (i[7:2] == base_t[b][7:2]) return b;
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] i);
        int b;
        b = bank_of(i);
        if (b < 0) return 8'h00;
        case (i[1:0])
            2'd0: return m_dir[b];
            2'd1: return m_dat[b];
            2'd2: return pad_in[b*8 +: 8] & msk(b);
            default: return m_mode[b];
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check64(input string req, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %016h expected %016h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        int b;
        @(negedge clk);
        reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        b = bank_of(i);
        if (b >= 0) begin
            case (i[1:0])
                2'd0: m_dir[b] = d & msk(b);
                2'd1: m_dat[b] = d & msk(b);
                2'd3: m_mode[b] = d & msk(b);
                default: ;
            endcase
        end
    endtask

    // R10: read data is checked shortly after the index changes, with no edge in between.
    task automatic rd_chk(input string req, input logic [7:0] i);
        @(negedge clk);
        reg_idx = i;
        #1 check8(req, reg_rdata, exp_read(i));
    endtask

    task automatic pad_chk(input string req);
        logic [NB*8-1:0] eo, ev;
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < 8; p++) begin
                logic o;
                o = (p < pins_t[b]) && m_dir[b][p] && (m_mode[b][p] || !m_dat[b][p]);
                eo[b*8+p] = o;
                ev[b*8+p] = o && m_dat[b][p];
            end
        end
        @(negedge clk);
        check64({req, " oe"}, pad_oe, eo);
        check64({req, " out"}, pad_out, ev);
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '0; m_dat[b] = '0; m_mode[b] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R1: reset state of every register and pad
        pad_chk("R1 reset pads");
        for (int i = 0; i < 256; i++) rd_chk("R1 reset read", 8'(i));

        // R2 R8 R9 R7: write every index, then read every index back
        for (int i = 0; i < 256; i++) wr(8'(i), 8'((i * 37 + 11) ^ 8'hA5));
        for (int i = 0; i < 256; i++) rd_chk("R2 R8 R9 map sweep", 8'(i));
        // R3 R4 R5 R8: pads after the sweep
        pad_chk("R3 R4 R5 R8 sweep pads");

        // R3 R4 R5: many pattern combinations on every bank
        for (int k = 0; k < 24; k++) begin
            for (int b = 0; b < NB; b++) begin
                wr(base_t[b] + 8'd1, 8'((k * 29 + b * 7) ^ 8'h3C));
                wr(base_t[b] + 8'd3, 8'((k * 53 + b * 13) ^ 8'hC3));
                wr(base_t[b] + 8'd0, 8'((k * 71 + b * 19) ^ 8'h5A));
            end
            pad_chk("R3 R4 R5 pattern");
        end

        // R6: preload data while input, then turn pins to outputs
        for (int b = 0; b < NB; b++) begin
            wr(base_t[b] + 8'd0, 8'h00);
            wr(base_t[b] + 8'd3, 8'hFF);
            wr(base_t[b] + 8'd1, 8'(8'h96 ^ b));
        end
        pad_chk("R6 preload while input");
        for (int b = 0; b < NB; b++) wr(base_t[b] + 8'd0, 8'hFF);
        pad_chk("R6 preload driven");

        // R5: open-drain with all data high releases every pad
        for (int b = 0; b < NB; b++) begin
            wr(base_t[b] + 8'd3, 8'h00);
            wr(base_t[b] + 8'd1, 8'hFF);
        end
        pad_chk("R5 open-drain released");

        // R7: status latency and independence from direction
        for (int k = 0; k < 8; k++) begin
            logic [NB*8-1:0] prev;
            prev = pad_in;
            @(negedge clk);
            pad_in = {8{8'(k * 45 + 17)}} ^ {NB{8'(k)}} ^ 64'h0123_4567_89AB_CDEF;
            @(posedge clk);
            @(negedge clk);
            #1;
            for (int b = 0; b < NB; b++) begin
                reg_idx = base_t[b] + 8'd2;
                #1 check8("R7 status one edge", reg_rdata, prev[b*8 +: 8] & msk(b));
            end
            @(posedge clk);
            for (int b = 0; b < NB; b++) rd_chk("R7 status two edges", base_t[b] + 8'd2);
            if (k == 3) begin
                for (int b = 0; b < NB; b++) wr(base_t[b] + 8'd0, 8'h00);
            end
        end
        // R7: writing status changes nothing
        for (int b = 0; b < NB; b++) wr(base_t[b] + 8'd2, 8'hFF);
        for (int i = 0; i < 256; i++) rd_chk("R7 status write ignored", 8'(i));
        pad_chk("R7 pads after status write");

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0; pad_in = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '0; m_dat[b] = '0; m_mode[b] = '0;
        end
        repeat (2) @(posedge clk);
        pad_chk("R1 second reset pads");
        for (int i = 0; i < 256; i++) rd_chk("R1 second reset read", 8'(i));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule